// File: doc/BRIEF.md
# Serial 5B Symbol Framer with Line-State Tracking

This block sits behind a clock-recovery and NRZI-decoding front end. It accepts a stream of 5B code bits, one per clock when a valid strobe is high, and cuts it into ten-bit symbol pairs. Each pair becomes a ten-bit parallel word: an odd-parity bit, a control flag, and one 4-bit nibble per symbol. Data symbols carry their 4-bit value. Control and invalid symbols carry fixed code nibbles.

Pair boundaries come from the starting-delimiter pair (J followed by K), which can appear at any bit offset. A hold input suppresses realignment, so that a delimiter seen at the wrong offset cannot tear apart a stream already in progress. Each time the alignment moves, a one-cycle pulse is raised.

The block also tracks the line state from the decoded pairs: Idle, Super Idle (a long unbroken run of Idle pairs) or Active (after a delimiter). Each change of line state is marked by a single-cycle pulse.

Top module: `fr5b_framer`

## Requirements
- R1: After reset, the first ten valid bits form the first pair, and every further ten valid bits form the next pair. `word_vld_o` is high for exactly one cycle, in the cycle that follows the clock edge that takes a pair's last bit. The earliest-received bit is the MSB of the first symbol.
- R2: Word layout is [9] parity, [8] control flag, [7:4] first symbol nibble, [3:0] second symbol nibble. The data codes for nibbles 0 to F are, in nibble order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. A pair of two data codes gives control flag 0 and no violation.
- R3: A control code sets the control flag and yields its own nibble: 11111 (Idle) gives 1010; 11000 (J) and 10001 (K) give 1101; 01101 gives 0101; 00111 gives 0100; 11001 gives 0111; 00000 gives 0000; 00100 gives 0001. A data symbol paired with a control symbol keeps its data nibble.
- R4: Any other 5-bit code sets the control flag, yields nibble 0010, and raises `code_viol_o` together with that word.
- R5: The parity bit makes the number of ones across all ten bits of the word odd.
- R6: With `frame_hold_i` low, the ten most recent bits equal to 11000_10001 produce a word on that bit at any offset, and the next pair starts with the following bit.
- R7: `realign_o` pulses for one cycle, one cycle after the word of a delimiter that moved the alignment. A delimiter that is already aligned gives no pulse.
- R8: With `frame_hold_i` high, a delimiter at the wrong offset is ignored: no word and no realignment. A delimiter at the current alignment is still decoded.
- R9: `line_state_o` encodes 0 none (after reset), 1 Idle, 2 Super Idle and 3 Active. A JK pair sets Active. An Idle pair (11111 11111) sets Idle unless R10 applies. Any other pair leaves the state unchanged.
- R10: The 8th consecutive Idle pair (parameter SUPER_RUN) sets Super Idle, and further Idle pairs keep it. After 7 Idle pairs the state is still Idle.
- R11: `ls_change_o` is high for one cycle, in the first cycle in which `line_state_o` shows a new value, and is low at all other times.
- R12: A cycle with `bit_vld_i` low takes no bit and produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_i | input | 1 | Serial 5B code bit |
| bit_vld_i | input | 1 | Qualifies bit_i |
| frame_hold_i | input | 1 | Suppresses realignment on a misaligned delimiter |
| word_o | output | 10 | Parity, control flag, two nibbles |
| word_vld_o | output | 1 | One-cycle strobe for word_o |
| code_viol_o | output | 1 | Word held an invalid code |
| line_state_o | output | 2 | 0 none, 1 Idle, 2 Super Idle, 3 Active |
| ls_change_o | output | 1 | One-cycle pulse on a line-state change |
| realign_o | output | 1 | One-cycle pulse after the alignment moves |

## Verification
Aligned runs of Idle pairs show where the 7-versus-8 Super Idle threshold falls and when the change pulse fires. Delimiters are sent at a shifted offset and at the current offset, each with the hold input high and low. These four cases separate a true realignment from a JK pair that is only decoded, and show whether the hold input gates realignment only. Random data pairs sent with random gaps in the valid strobe check the nibble table and the parity, and check that idle cycles take no bit. Random 5-bit codes, held in framing, cover the control and invalid code mapping.

// File: rtl/fr5b_pkg.sv
package fr5b_pkg;
    localparam int SYM_W  = 5;
    localparam int NIB_W  = 4;
    localparam int PAIR_W = 2 * SYM_W;
    localparam int WORD_W = 2 * NIB_W + 2;

    typedef enum logic [1:0] {
        LS_NONE   = 2'd0,
        LS_IDLE   = 2'd1,
        LS_SUPER  = 2'd2,
        LS_ACTIVE = 2'd3
    } ls_e;

    localparam logic [PAIR_W-1:0] PAIR_JK   = 10'b11000_10001;
    localparam logic [PAIR_W-1:0] PAIR_IDLE = 10'b11111_11111;

    localparam logic [NIB_W-1:0] NIB_IDLE = 4'b1010;
    localparam logic [NIB_W-1:0] NIB_DELIM = 4'b1101;
    localparam logic [NIB_W-1:0] NIB_END  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_RST  = 4'b0100;
    localparam logic [NIB_W-1:0] NIB_SET  = 4'b0111;
    localparam logic [NIB_W-1:0] NIB_QUIET = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_HALT = 4'b0001;
    localparam logic [NIB_W-1:0] NIB_BAD  = 4'b0010;
endpackage

// File: rtl/fr5b_symdec.sv
module fr5b_symdec
    import fr5b_pkg::*;
(
    input  logic [SYM_W-1:0] code_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             ctl_o,
    output logic             bad_o
);
    always_comb begin
        nib_o = NIB_BAD;
        ctl_o = 1'b1;
        bad_o = 1'b0;
        unique case (code_i)
            5'b11110: begin nib_o = 4'h0; ctl_o = 1'b0; end
            5'b01001: begin nib_o = 4'h1; ctl_o = 1'b0; end
            5'b10100: begin nib_o = 4'h2; ctl_o = 1'b0; end
            5'b10101: begin nib_o = 4'h3; ctl_o = 1'b0; end
            5'b01010: begin nib_o = 4'h4; ctl_o = 1'b0; end
            5'b01011: begin nib_o = 4'h5; ctl_o = 1'b0; end
            5'b01110: begin nib_o = 4'h6; ctl_o = 1'b0; end
            5'b01111: begin nib_o = 4'h7; ctl_o = 1'b0; end
            5'b10010: begin nib_o = 4'h8; ctl_o = 1'b0; end
            5'b10011: begin nib_o = 4'h9; ctl_o = 1'b0; end
            5'b10110: begin nib_o = 4'hA; ctl_o = 1'b0; end
            5'b10111: begin nib_o = 4'hB; ctl_o = 1'b0; end
            5'b11010: begin nib_o = 4'hC; ctl_o = 1'b0; end
            5'b11011: begin nib_o = 4'hD; ctl_o = 1'b0; end
            5'b11100: begin nib_o = 4'hE; ctl_o = 1'b0; end
            5'b11101: begin nib_o = 4'hF; ctl_o = 1'b0; end
            5'b11111: nib_o = NIB_IDLE;
            5'b11000: nib_o = NIB_DELIM;
            5'b10001: nib_o = NIB_DELIM;
            5'b01101: nib_o = NIB_END;
            5'b00111: nib_o = NIB_RST;
            5'b11001: nib_o = NIB_SET;
            5'b00000: nib_o = NIB_QUIET;
            5'b00100: nib_o = NIB_HALT;
            default:  bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/fr5b_lstate.sv
module fr5b_lstate
    import fr5b_pkg::*;
#(
    parameter int SUPER_RUN = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pair_vld_i,
    input  logic       pair_idle_i,
    input  logic       pair_jk_i,
    output logic [1:0] state_o,
    output logic       change_o
);
    localparam int RUN_W = $clog2(SUPER_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SUPER_RUN);

    typedef struct packed {
        ls_e              st;
        logic [RUN_W-1:0] run;
        logic             chg;
    } ls_t;

    ls_t d, q;

    always_comb begin
        logic [RUN_W-1:0] run_n;
        ls_e              st_n;
        d     = q;
        d.chg = 1'b0;
        run_n = q.run;
        st_n  = q.st;
        if (pair_vld_i) begin
            if (pair_jk_i) begin
                run_n = '0;
                st_n  = LS_ACTIVE;
            end else if (pair_idle_i) begin
                run_n = (q.run >= RUN_MAX) ? RUN_MAX : q.run + 1'b1;
                st_n  = (run_n >= RUN_MAX) ? LS_SUPER : LS_IDLE;
            end else begin
                run_n = '0;
            end
        end
        d.run = run_n;
        d.st  = st_n;
        d.chg = (st_n != q.st);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: LS_NONE, run: '0, chg: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign state_o  = q.st;
    assign change_o = q.chg;
endmodule

// File: rtl/fr5b_framer.sv
module fr5b_framer
    import fr5b_pkg::*;
#(
    parameter int SUPER_RUN = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bit_i,
    input  logic        bit_vld_i,
    input  logic        frame_hold_i,
    output logic [9:0]  word_o,
    output logic        word_vld_o,
    output logic        code_viol_o,
    output logic [1:0]  line_state_o,
    output logic        ls_change_o,
    output logic        realign_o
);
    localparam int PH_W = $clog2(PAIR_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAIR_W - 1);

    typedef struct packed {
        logic [PAIR_W-1:0] sr;
        logic [PH_W-1:0]   ph;
        logic [WORD_W-1:0] word;
        logic              wvld;
        logic              viol;
        logic              pend;
        logic              realign;
    } fr_t;

    fr_t d, q;

    logic [PAIR_W-1:0] sr_nx;
    logic [NIB_W-1:0]  nib  [2];
    logic              ctl  [2];
    logic              bad  [2];
    logic              at_edge, jk_seen, jk_take, pair_take;
    logic              ctl_any, bad_any;
    logic [2*NIB_W-1:0] data_w;

    assign sr_nx = {q.sr[PAIR_W-2:0], bit_i};

    for (genvar s = 0; s < 2; s++) begin : g_sym
        fr5b_symdec u_dec (
            .code_i (sr_nx[s*SYM_W +: SYM_W]),
            .nib_o  (nib[s]),
            .ctl_o  (ctl[s]),
            .bad_o  (bad[s])
        );
    end

    assign at_edge   = (q.ph == PH_LAST);
    assign jk_seen   = (sr_nx == PAIR_JK);
    assign jk_take   = jk_seen && (at_edge || !frame_hold_i);
    assign pair_take = bit_vld_i && (at_edge || jk_take);
    assign ctl_any   = ctl[0] | ctl[1];
    assign bad_any   = bad[0] | bad[1];
    assign data_w    = {nib[1], nib[0]};

    always_comb begin
        d         = q;
        d.wvld    = 1'b0;
        d.pend    = 1'b0;
        d.realign = q.pend;
        if (bit_vld_i) begin
            d.sr = sr_nx;
            if (pair_take) begin
                d.ph   = '0;
                d.wvld = 1'b1;
                d.viol = bad_any;
                d.word = {~^{ctl_any, data_w}, ctl_any, data_w};
                d.pend = !at_edge;
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    fr5b_lstate #(.SUPER_RUN(SUPER_RUN)) u_ls (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pair_vld_i  (pair_take),
        .pair_idle_i (sr_nx == PAIR_IDLE),
        .pair_jk_i   (jk_seen),
        .state_o     (line_state_o),
        .change_o    (ls_change_o)
    );

    assign word_o      = q.word;
    assign word_vld_o  = q.wvld;
    assign code_viol_o = q.viol;
    assign realign_o   = q.realign;
endmodule

// File: rtl/fr5b_checker.sv
module fr5b_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bit_vld_i,
    input logic [9:0] word_o,
    input logic       word_vld_o,
    input logic       code_viol_o,
    input logic [1:0] line_state_o,
    input logic       ls_change_o,
    input logic       realign_o
);
    assert_odd_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |-> (^word_o));

    assert_viol_is_ctrl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld_o && code_viol_o) |-> word_o[8]);

    assert_no_word_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(bit_vld_i) |-> !word_vld_o);

    assert_realign_after_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        realign_o |-> $past(word_vld_o));

    assert_change_marks_new_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ls_change_o |-> (line_state_o != $past(line_state_o)));

    assert_new_has_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_state_o != $past(line_state_o)) |-> ls_change_o);

    assert_super_from_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_state_o == 2'd2 && $past(line_state_o) != 2'd2)
            |-> (word_vld_o && word_o[8:0] == 9'h1AA));

    assert_state_moves_on_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_state_o != $past(line_state_o)) |-> word_vld_o);
endmodule

bind fr5b_framer fr5b_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_vld_i    (bit_vld_i),
    .word_o       (word_o),
    .word_vld_o   (word_vld_o),
    .code_viol_o  (code_viol_o),
    .line_state_o (line_state_o),
    .ls_change_o  (ls_change_o),
    .realign_o    (realign_o)
);

// File: tb/fr5b_framer_tb_top.sv
module fr5b_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic       hold = 1'b0;
    logic [9:0] word;
    logic       word_vld, viol, ls_chg, realign;
    logic [1:0] ls;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fr5b_framer dut_i (
        .clk_i (clk), .rst_ni (rst_n), .bit_i (bit_in), .bit_vld_i (bit_vld),
        .frame_hold_i (hold), .word_o (word), .word_vld_o (word_vld),
        .code_viol_o (viol), .line_state_o (ls), .ls_change_o (ls_chg),
        .realign_o (realign)
    );

    localparam logic [4:0] C_I = 5'b11111, C_J = 5'b11000, C_K = 5'b10001;

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    // returns {bad, ctrl, nibble} per R2/R3/R4
    function automatic logic [5:0] expect_sym(input logic [4:0] c);
        for (int n = 0; n < 16; n++)
            if (enc(4'(n)) == c) return {2'b00, 4'(n)};
        case (c)
            5'b11111: return {2'b01, 4'b1010};
            5'b11000, 5'b10001: return {2'b01, 4'b1101};
            5'b01101: return {2'b01, 4'b0101};
            5'b00111: return {2'b01, 4'b0100};
            5'b11001: return {2'b01, 4'b0111};
            5'b00000: return {2'b01, 4'b0000};
            5'b00100: return {2'b01, 4'b0001};
            default:  return {2'b11, 4'b0010};
        endcase
    endfunction

    function automatic logic [10:0] expect_word(input logic [4:0] a, input logic [4:0] b);
        logic [5:0] ea, eb;
        logic       c;
        ea = expect_sym(a);
        eb = expect_sym(b);
        c  = ea[4] | eb[4];
        return {ea[5] | eb[5], ~^{c, ea[3:0], eb[3:0]}, c, ea[3:0], eb[3:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit gaps);
        if (gaps && $urandom_range(3) == 0) begin
            @(negedge clk); bit_vld = 1'b0;
            @(posedge clk);
        end
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(posedge clk);
    endtask

    task automatic send_code(input logic [4:0] c, input bit gaps);
        for (int i = 4; i >= 0; i--) send_bit(c[i], gaps);
    endtask

    task automatic send_pair(input logic [4:0] a, input logic [4:0] b, input bit gaps);
        send_code(a, gaps);
        send_code(b, gaps);
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic check_word(input logic [4:0] a, input logic [4:0] b, input string tag);
        logic [10:0] e;
        e = expect_word(a, b);
        check(word_vld == 1'b1, {tag, " vld"}, word_vld, 1);
        check(word == e[9:0], {tag, " word"}, word, e[9:0]);
        check(viol == e[10], {tag, " viol"}, viol, e[10]);
    endtask

    task automatic check_realign(input logic exp, input string tag);
        @(posedge clk); @(negedge clk);
        check(realign == exp, tag, realign, exp);
        check(word_vld == 1'b0, {tag, " vld drop R1"}, word_vld, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(word_vld == 0 && realign == 0 && ls_chg == 0, "reset R1 R7 R11", word_vld, 0);
        check(ls == 2'd0, "reset state R9", ls, 0);
        rst_n = 1'b1;

        // R1 R3 R9 R11: first Idle pair at reset alignment
        send_pair(C_I, C_I, 1'b0);
        check_word(C_I, C_I, "idle pair R1 R3");
        check(ls == 2'd1, "idle state R9", ls, 1);
        check(ls_chg == 1'b1, "idle change R11", ls_chg, 1);
        for (int k = 2; k <= 7; k++) begin
            send_pair(C_I, C_I, 1'b0);
            check(ls == 2'd1, "still idle R10", ls, 1);
            check(ls_chg == 1'b0, "no change R11", ls_chg, 0);
        end
        send_pair(C_I, C_I, 1'b0);
        check(ls == 2'd2, "eighth idle super R10", ls, 2);
        check(ls_chg == 1'b1, "super change R11", ls_chg, 1);
        send_pair(C_I, C_I, 1'b0);
        check(ls == 2'd2 && ls_chg == 1'b0, "super kept R10", ls, 2);

        // R6 R7: shifted delimiter realigns
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
        send_pair(C_J, C_K, 1'b0);
        check_word(C_J, C_K, "shifted jk R6");
        check(ls == 2'd3 && ls_chg == 1'b1, "active R9 R11", ls, 3);
        check_realign(1'b1, "realign pulse R7");

        // R7: aligned delimiter gives no pulse
        send_pair(C_J, C_K, 1'b0);
        check_word(C_J, C_K, "aligned jk R6");
        check(ls_chg == 1'b0, "active kept R11", ls_chg, 0);
        check_realign(1'b0, "aligned no pulse R7");

        // R2 R5 R12: random data with valid gaps
        for (int p = 0; p < 24; p++) begin
            logic [4:0] a, b;
            a = enc(4'($urandom_range(15)));
            b = enc(4'($urandom_range(15)));
            send_pair(a, b, 1'b1);
            check_word(a, b, "data R2 R5 R12");
        end

        // R3 R4 directed
        send_pair(5'b00001, enc(4'h5), 1'b0);
        check_word(5'b00001, enc(4'h5), "invalid R4");
        check(viol == 1'b1, "viol flag R4", viol, 1);
        send_pair(5'b01101, 5'b00111, 1'b0);
        check_word(5'b01101, 5'b00111, "ctrl pair R3");

        // R8: held, misaligned delimiter ignored
        send_pair(C_I, C_I, 1'b0);
        check(ls == 2'd1, "back to idle R9", ls, 1);
        hold = 1'b1;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        send_pair(C_J, C_K, 1'b0);
        check(word_vld == 1'b0, "held jk no word R8", word_vld, 0);
        check(ls == 2'd1, "held jk state R8", ls, 1);
        check_realign(1'b0, "held no realign R8");
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
        @(negedge clk); bit_vld = 1'b0;
        check(word_vld == 1'b1, "old alignment kept R8", word_vld, 1);
        send_pair(C_J, C_K, 1'b0);
        check_word(C_J, C_K, "held aligned jk R8");
        check(ls == 2'd3, "held aligned active R8", ls, 3);
        check_realign(1'b0, "held aligned no pulse R8");

        // R2 R3 R4 R5: random 5-bit codes, framing held
        for (int p = 0; p < 40; p++) begin
            logic [4:0] a, b;
            a = 5'($urandom_range(31));
            b = 5'($urandom_range(31));
            send_pair(a, b, 1'b1);
            check_word(a, b, "random code R3 R4 R5");
        end
        hold = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule